// File: doc/BRIEF.md
# SCSI Host Controller Interrupt and Status Unit

This block keeps the interrupt-cause, status and sequence-step registers of a byte-wide, memory-mapped SCSI host controller. It also drives the controller's single interrupt line. A command decoder next to it sends one-cycle event pulses: chip reset, bus reset, FIFO flush, selection finished and transfer finished. The device side sends a completion pulse that carries a status byte. Software sees the results through register reads.

Reading the interrupt-cause register returns its old value and clears the interrupt. If a completion arrives while an interrupt is still unacknowledged, it is not reported at once. The block holds it, and it becomes the next interrupt as soon as software reads the interrupt-cause register. Until software has written the top transfer-count byte, a read of that location returns a fixed identification byte. Software uses this byte to detect the controller variant.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, irq is 0 and the following registers read as shown: status 0x00, interrupt-cause 0x00, sequence step 0, config-1 0x07, transfer-count bytes 0x00.
- R2: The high transfer-count byte (index 2) reads CHIP_ID (default 0xA2) until it has been written once since the last reset. After that it reads the written value.
- R3: A byte read of the interrupt-cause register (index 4) returns its value before the access. On the same clock edge, the block clears that register, clears the TC bit (status bit 4) and the INT bit (status bit 7), sets the sequence step (index 5) to 4 and drives irq low.
- R4: A completion that arrives while INT is set is held and not reported: status, interrupt-cause and irq stay unchanged. The next interrupt-cause read returns the old cause and then reports the held completion on that same edge.
- R5: Reporting a completion has these effects: the status register becomes 0x93 (INT, TC, phase 3 in bits 2:0); interrupt-cause becomes 0x10; the sequence step becomes 0; all three transfer-count bytes become 0; the status byte is stored (index 9); irq goes high.
- R6: A bus-reset event sets interrupt-cause to 0x80. It raises irq only when config-1 bit 6 is 0.
- R7: A flush event sets interrupt-cause to 0x08 and the sequence step to 0, and leaves irq and INT unchanged.
- R8: A transfer-done event sets TC and INT in status, sets interrupt-cause to 0x10, sets the sequence step to 0, zeroes the transfer-count bytes and raises irq.
- R9: A selection-done event sets interrupt-cause to 0x18 and the sequence step to 4, and raises irq.
- R10: A chip-reset event drives irq low and returns every register to its reset value. Config-1 then reads 0x07, and the identification readback is armed again.
- R11: The register index is bus_addr shifted right by ADDR_SHIFT (default 2), so only index bits are decoded. Access size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Byte reads and writes are accepted, and 4-byte writes are accepted. Any other access is ignored: it has no side effect, and bus_rdata keeps its last value.
- R12: A write to any transfer-count byte (indices 0 to 2) clears TC. Writes to status (3), interrupt-cause (4), step (5) and stored status (9) are ignored.
- R13: irq always equals the INT bit of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins over bus_rd) |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after an accepted read |
| ev_chip_rst | input | 1 | Chip-reset command pulse |
| ev_bus_rst | input | 1 | Bus-reset command pulse |
| ev_flush | input | 1 | FIFO-flush command pulse |
| ev_sel_done | input | 1 | Selection-finished pulse |
| ev_xfer_done | input | 1 | Transfer-finished pulse |
| cmpl_valid | input | 1 | Command-completion pulse |
| cmpl_code | input | 8 | Status byte carried by the completion |
| irq | output | 1 | Interrupt line, active high |

## Verification
The hardest case to reach is a completion that lands while an earlier interrupt is still pending, with the held completion then released by the acknowledging read. The bench gets there by raising an interrupt with a selection-done pulse first, then sending the completion. It confirms that status and the stored status byte have not moved. It then reads the interrupt-cause register and checks that the read returns the selection cause. Immediately afterwards, irq must still be high and the completion values must be visible. A second acknowledging read then shows that the interrupt line finally drops.

// File: rtl/scsi_isu_pkg.sv
package scsi_isu_pkg;

  localparam int IDX_W = 4;

  // register indices
  localparam logic [IDX_W-1:0] IX_XCNT0 = 4'd0;
  localparam logic [IDX_W-1:0] IX_XCNT1 = 4'd1;
  localparam logic [IDX_W-1:0] IX_XCNT2 = 4'd2;
  localparam logic [IDX_W-1:0] IX_STAT  = 4'd3;
  localparam logic [IDX_W-1:0] IX_INTR  = 4'd4;
  localparam logic [IDX_W-1:0] IX_STEP  = 4'd5;
  localparam logic [IDX_W-1:0] IX_CFG1  = 4'd6;
  localparam logic [IDX_W-1:0] IX_CFG2  = 4'd7;
  localparam logic [IDX_W-1:0] IX_CFG3  = 4'd8;
  localparam logic [IDX_W-1:0] IX_CSTAT = 4'd9;

  // status bits and codes decoded by software
  localparam int         ST_INT    = 7;
  localparam int         ST_TC     = 4;
  localparam logic [2:0] PH_STATUS = 3'd3;

  localparam logic [7:0] IR_RST   = 8'h80;
  localparam logic [7:0] IR_BSVC  = 8'h10;
  localparam logic [7:0] IR_FDONE = 8'h08;

  localparam logic [2:0] STEP_CMD_DONE = 3'd4;
  localparam logic [7:0] CFG1_RST_VAL  = 8'h07;
  localparam int         CFG1_NORPT    = 6;

  // access size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic [7:0] stat;
    logic [7:0] intr;
    logic [2:0] step;
    logic [7:0] xc0;
    logic [7:0] xc1;
    logic [7:0] xc2;
    logic [7:0] cfg1;
    logic [7:0] cfg2;
    logic [7:0] cfg3;
    logic [7:0] cstat;
    logic       hi_wr;
    logic       pend;
    logic [7:0] pend_stat;
  } isu_state_t;

  function automatic isu_state_t st_reset();
    isu_state_t r;
    r      = '0;
    r.cfg1 = CFG1_RST_VAL;
    return r;
  endfunction

  // completion report: status phase, TC, bus-service cause, counters zeroed
  function automatic isu_state_t st_report(isu_state_t s, logic [7:0] code);
    isu_state_t r;
    r              = s;
    r.cstat        = code;
    r.stat         = {5'b0, PH_STATUS};
    r.stat[ST_TC]  = 1'b1;
    r.stat[ST_INT] = 1'b1;
    r.intr         = IR_BSVC;
    r.step         = 3'd0;
    r.xc0          = 8'h00;
    r.xc1          = 8'h00;
    r.xc2          = 8'h00;
    return r;
  endfunction

  function automatic logic acc_ok(logic is_wr, logic [1:0] sz);
    return (sz == SZ_BYTE) || (is_wr && sz == SZ_WORD);
  endfunction

endpackage

// File: rtl/scsi_isu_decode.sv
module scsi_isu_decode
  import scsi_isu_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_ok,
  output logic              wr_ok
);
  localparam int TOP = ADDR_SHIFT + IDX_W;
  localparam logic [ADDR_W-1:0] IDX_MASK =
    ADDR_W'(((1 << IDX_W) - 1) << ADDR_SHIFT);

  initial begin
    if (TOP > ADDR_W) $error("address too narrow for register index");
  end

  assign idx   = IDX_W'(addr >> ADDR_SHIFT);
  assign wr_ok = wr && acc_ok(1'b1, size);
  assign rd_ok = rd && !wr && acc_ok(1'b0, size);

  // bits outside the index field are not decoded
  logic unused_addr_bits;
  assign unused_addr_bits = ^(addr & ~IDX_MASK);
endmodule

// File: rtl/scsi_isu_regs.sv
module scsi_isu_regs
  import scsi_isu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd_ok,
  input  logic             wr_ok,
  input  logic [7:0]       wdata,
  input  logic             ev_chip_rst,
  input  logic             ev_bus_rst,
  input  logic             ev_flush,
  input  logic             ev_sel_done,
  input  logic             ev_xfer_done,
  input  logic             cmpl_valid,
  input  logic [7:0]       cmpl_code,
  output isu_state_t       st,
  output logic             irq
);
  isu_state_t s, n;
  logic irq_q, irq_set, irq_clr;
  logic intr_rd, quiet;

  assign intr_rd = rd_ok && (idx == IX_INTR);
  assign quiet   = !(ev_flush || ev_bus_rst || ev_sel_done ||
                     ev_xfer_done || ev_chip_rst);

  always_comb begin
    n       = s;
    irq_set = 1'b0;
    irq_clr = 1'b0;

    if (wr_ok) begin
      unique case (idx)
        IX_XCNT0: begin n.xc0 = wdata; n.stat[ST_TC] = 1'b0; end
        IX_XCNT1: begin n.xc1 = wdata; n.stat[ST_TC] = 1'b0; end
        IX_XCNT2: begin
          n.xc2 = wdata; n.hi_wr = 1'b1; n.stat[ST_TC] = 1'b0;
        end
        IX_CFG1: n.cfg1 = wdata;
        IX_CFG2: n.cfg2 = wdata;
        IX_CFG3: n.cfg3 = wdata;
        default: ;
      endcase
    end

    if (intr_rd) begin
      n.intr         = 8'h00;
      n.stat[ST_TC]  = 1'b0;
      n.step         = STEP_CMD_DONE;
      if (n.stat[ST_INT]) begin
        n.stat[ST_INT] = 1'b0;
        irq_clr        = 1'b1;
      end
      if (s.pend) begin
        n       = st_report(n, s.pend_stat);
        n.pend  = 1'b0;
        irq_set = 1'b1;
      end
    end

    if (ev_flush) begin
      n.intr = IR_FDONE;
      n.step = 3'd0;
    end

    if (ev_bus_rst) begin
      n.intr = IR_RST;
      if (!n.cfg1[CFG1_NORPT]) begin
        n.stat[ST_INT] = 1'b1;
        irq_set        = 1'b1;
      end
    end

    if (ev_sel_done) begin
      n.intr         = IR_BSVC | IR_FDONE;
      n.step         = STEP_CMD_DONE;
      n.stat[ST_INT] = 1'b1;
      irq_set        = 1'b1;
    end

    if (ev_xfer_done) begin
      n.stat[ST_TC]  = 1'b1;
      n.stat[ST_INT] = 1'b1;
      n.intr         = IR_BSVC;
      n.step         = 3'd0;
      n.xc0          = 8'h00;
      n.xc1          = 8'h00;
      n.xc2          = 8'h00;
      irq_set        = 1'b1;
    end

    if (cmpl_valid) begin
      if (n.stat[ST_INT]) begin
        n.pend      = 1'b1;
        n.pend_stat = cmpl_code;
      end else begin
        n       = st_report(n, cmpl_code);
        irq_set = 1'b1;
      end
    end

    if (ev_chip_rst) begin
      n       = st_reset();
      irq_set = 1'b0;
      irq_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s     <= st_reset();
      irq_q <= 1'b0;
    end else begin
      s <= n;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign st  = s;
  assign irq = irq_q;

  // R13: line and status bit are separate flops and must agree
  p_irq_mirror_r13: assert property (@(posedge clk) disable iff (rst)
    irq_q == s.stat[ST_INT]);

  // R3: plain acknowledge clears cause, TC, INT and sets step
  p_intr_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (intr_rd && !s.pend && quiet && !cmpl_valid) |=>
      (!irq_q && s.intr == 8'h00 && s.step == STEP_CMD_DONE && !s.stat[ST_TC]));

  // R4: completion during pending interrupt is held
  p_defer_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (cmpl_valid && s.stat[ST_INT] && !intr_rd && quiet) |=>
      (s.pend && irq_q && s.pend_stat == $past(cmpl_code) &&
       s.intr == $past(s.intr)));

  // R4: acknowledge releases the held completion
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (intr_rd && s.pend && !ev_chip_rst) |=>
      (irq_q && s.stat[ST_INT] && s.cstat == $past(s.pend_stat)));

  // R6: masked bus reset leaves the line low
  p_busrst_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_bus_rst && s.cfg1[CFG1_NORPT] && !s.stat[ST_INT] && !wr_ok &&
     !intr_rd && !ev_sel_done && !ev_xfer_done && !cmpl_valid) |=> !irq_q);

  // R10: chip reset restores defaults
  p_chip_rst_r10: assert property (@(posedge clk) disable iff (rst)
    ev_chip_rst |=> (!irq_q && s.cfg1 == CFG1_RST_VAL && s.intr == 8'h00 &&
                     !s.hi_wr && !s.pend));
endmodule

// File: rtl/scsi_isu_rdmux.sv
module scsi_isu_rdmux
  import scsi_isu_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hA2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd_ok,
  input  isu_state_t       st,
  output logic [7:0]       rdata
);
  function automatic logic [7:0] sel_val(isu_state_t s, logic [IDX_W-1:0] i);
    logic [7:0] v;
    unique case (i)
      IX_XCNT0: v = s.xc0;
      IX_XCNT1: v = s.xc1;
      IX_XCNT2: v = s.hi_wr ? s.xc2 : CHIP_ID;
      IX_STAT:  v = s.stat;
      IX_INTR:  v = s.intr;
      IX_STEP:  v = {5'b0, s.step};
      IX_CFG1:  v = s.cfg1;
      IX_CFG2:  v = s.cfg2;
      IX_CFG3:  v = s.cfg3;
      IX_CSTAT: v = s.cstat;
      default:  v = 8'h00;
    endcase
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_ok) rdata <= sel_val(st, idx);
  end

  logic unused_state_bits;
  assign unused_state_bits = ^{st.pend, st.pend_stat};

  // R2: identification byte until the high count byte is written
  p_chip_id_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && idx == IX_XCNT2 && !st.hi_wr) |=> rdata == CHIP_ID);

  // R11: rejected or absent reads leave the data register alone
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |=> $stable(rdata));
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_isu_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         ADDR_SHIFT = 2,
  parameter logic [7:0] CHIP_ID    = 8'hA2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_chip_rst,
  input  logic              ev_bus_rst,
  input  logic              ev_flush,
  input  logic              ev_sel_done,
  input  logic              ev_xfer_done,
  input  logic              cmpl_valid,
  input  logic [7:0]        cmpl_code,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic             rd_ok, wr_ok;
  isu_state_t       st;

  scsi_isu_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .size(bus_size),
    .idx(idx), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  scsi_isu_regs u_regs (
    .clk(clk), .rst(rst), .idx(idx), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .wdata(bus_wdata), .ev_chip_rst(ev_chip_rst), .ev_bus_rst(ev_bus_rst),
    .ev_flush(ev_flush), .ev_sel_done(ev_sel_done),
    .ev_xfer_done(ev_xfer_done), .cmpl_valid(cmpl_valid),
    .cmpl_code(cmpl_code), .st(st), .irq(irq)
  );

  scsi_isu_rdmux #(.CHIP_ID(CHIP_ID)) u_rd (
    .clk(clk), .rst(rst), .idx(idx), .rd_ok(rd_ok), .st(st),
    .rdata(bus_rdata)
  );
endmodule

// File: tb/scsi_irq_status_tb.sv
module scsi_irq_status_tb;
  localparam int SH = 2;
  localparam logic [7:0] ID = 8'hA2;

  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0, cmpl_code = 0;
  logic bus_rd = 0, bus_wr = 0, cmpl_valid = 0;
  logic [1:0] bus_size = 0;
  logic ev_chip_rst = 0, ev_bus_rst = 0, ev_flush = 0, ev_sel_done = 0, ev_xfer_done = 0;
  logic [7:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  scsi_irq_status u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_chip_rst(ev_chip_rst), .ev_bus_rst(ev_bus_rst), .ev_flush(ev_flush),
    .ev_sel_done(ev_sel_done), .ev_xfer_done(ev_xfer_done),
    .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(logic w, logic [7:0] a, logic [1:0] sz, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = w; bus_rd = !w;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(int i, logic [7:0] d);
    acc(1'b1, 8'(i << SH), 2'd0, d);
  endtask

  task automatic rd(int i, output logic [7:0] v);
    acc(1'b0, 8'(i << SH), 2'd0, 8'h00);
    v = bus_rdata;
  endtask

  task automatic expect_reg(string req, int i, logic [7:0] exp);
    logic [7:0] v;
    rd(i, v);
    check(req, v, exp);
  endtask

  task automatic pulse(int which, logic [7:0] code = 8'h00);
    @(negedge clk);
    case (which)
      0: ev_chip_rst = 1;
      1: ev_bus_rst = 1;
      2: ev_flush = 1;
      3: ev_sel_done = 1;
      4: ev_xfer_done = 1;
      default: begin cmpl_valid = 1; cmpl_code = code; end
    endcase
    @(negedge clk);
    ev_chip_rst = 0; ev_bus_rst = 0; ev_flush = 0;
    ev_sel_done = 0; ev_xfer_done = 0; cmpl_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 irq", {7'b0, irq}, 8'h00);
    expect_reg("R1 status", 3, 8'h00);
    expect_reg("R1 step", 5, 8'h00);
    expect_reg("R1 cause", 4, 8'h00);
    expect_reg("R1 cfg1", 6, 8'h07);
    expect_reg("R1 xcnt0", 0, 8'h00);
    expect_reg("R2 id before write", 2, ID);
  endtask

  task automatic t_chip_id;
    wr(2, 8'h3C);
    expect_reg("R2 written value", 2, 8'h3C);
    pulse(0);
    expect_reg("R10 id re-armed", 2, ID);
  endtask

  task automatic t_select_ack;
    pulse(3);
    check("R9 irq raised", {7'b0, irq}, 8'h01);
    rd(3, rv);
    check("R13 irq equals INT", {7'b0, irq}, {7'b0, rv[7]});
    check("R9 status INT", rv, 8'h80);
    expect_reg("R9 step", 5, 8'h04);
    expect_reg("R3 returns old cause", 4, 8'h18);
    check("R3 irq low", {7'b0, irq}, 8'h00);
    expect_reg("R3 cause cleared", 4, 8'h00);
    expect_reg("R3 status cleared", 3, 8'h00);
  endtask

  task automatic t_defer;
    pulse(3);
    pulse(5, 8'h02);
    check("R4 irq still set", {7'b0, irq}, 8'h01);
    expect_reg("R4 status not reported", 3, 8'h80);
    expect_reg("R4 stored status untouched", 9, 8'h00);
    expect_reg("R4 ack returns old cause", 4, 8'h18);
    check("R4 irq re-raised", {7'b0, irq}, 8'h01);
    expect_reg("R4 released status", 3, 8'h93);
    expect_reg("R4 released step", 5, 8'h00);
    expect_reg("R4 released code", 9, 8'h02);
    expect_reg("R4 second ack cause", 4, 8'h10);
    check("R4 irq low after second ack", {7'b0, irq}, 8'h00);
    expect_reg("R3 status keeps phase", 3, 8'h03);
  endtask

  task automatic t_direct;
    wr(0, 8'h55);
    pulse(5, 8'h05);
    check("R5 irq raised", {7'b0, irq}, 8'h01);
    expect_reg("R5 status", 3, 8'h93);
    expect_reg("R5 xcnt0 zeroed", 0, 8'h00);
    expect_reg("R5 stored code", 9, 8'h05);
    expect_reg("R5 cause", 4, 8'h10);
  endtask

  task automatic t_xfer;
    pulse(0);
    wr(1, 8'h22);
    pulse(4);
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    expect_reg("R8 status", 3, 8'h90);
    expect_reg("R8 xcnt1 zeroed", 1, 8'h00);
    wr(1, 8'h33);
    expect_reg("R12 count write clears TC", 3, 8'h80);
    wr(3, 8'hFF);
    expect_reg("R12 status write ignored", 3, 8'h80);
    wr(9, 8'h77);
    expect_reg("R12 stored status write ignored", 9, 8'h00);
    expect_reg("R8 cause", 4, 8'h10);
  endtask

  task automatic t_busrst;
    wr(6, 8'h47);
    pulse(1);
    check("R6 masked irq", {7'b0, irq}, 8'h00);
    expect_reg("R6 masked cause", 4, 8'h80);
    wr(6, 8'h07);
    pulse(1);
    check("R6 unmasked irq", {7'b0, irq}, 8'h01);
    expect_reg("R6 cause", 4, 8'h80);
  endtask

  task automatic t_flush;
    pulse(2);
    check("R7 irq unchanged low", {7'b0, irq}, 8'h00);
    expect_reg("R7 step", 5, 8'h00);
    expect_reg("R7 cause", 4, 8'h08);
    pulse(3);
    pulse(2);
    check("R7 irq unchanged high", {7'b0, irq}, 8'h01);
    expect_reg("R7 cause over select", 4, 8'h08);
  endtask

  task automatic t_decode;
    acc(1'b1, 8'h1D, 2'd0, 8'hA5);
    acc(1'b0, 8'h1C, 2'd0, 8'h00);
    check("R11 shifted index", bus_rdata, 8'hA5);
    acc(1'b1, 8'h1C, 2'd1, 8'h11);
    expect_reg("R11 2-byte write ignored", 7, 8'hA5);
    acc(1'b1, 8'h1C, 2'd2, 8'h3C);
    expect_reg("R11 4-byte write taken", 7, 8'h3C);
    pulse(3);
    acc(1'b0, 8'(4 << SH), 2'd2, 8'h00);
    check("R11 4-byte read no data", bus_rdata, 8'h3C);
    check("R11 4-byte read no clear", {7'b0, irq}, 8'h01);
    expect_reg("R11 cause intact", 4, 8'h18);
  endtask

  task automatic t_chiprst;
    wr(6, 8'h40);
    wr(8, 8'h11);
    pulse(3);
    pulse(0);
    check("R10 irq low", {7'b0, irq}, 8'h00);
    expect_reg("R10 cfg1", 6, 8'h07);
    expect_reg("R10 cfg3", 8, 8'h00);
    expect_reg("R10 cause", 4, 8'h00);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_chip_id;
    t_select_ack;
    t_defer;
    t_direct;
    t_xfer;
    t_busrst;
    t_flush;
    t_decode;
    t_chiprst;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule